// File: doc/BRIEF.md
# Configurable Output Macrocell Bank

This block is the output stage of a small programmable logic device. It holds eight cells. Each cell takes a sum-of-products result and a dedicated enable product term from the logic array, and it returns three things: a pin value, a pin enable and a feedback bit for the array. The pin is modelled as separate out, out-enable and in signals. A configuration word sets what every cell does. It has two global bits, a no-register bit and an I/O-architecture bit. Each cell also has two local bits: a select bit and a polarity bit.

Each cell decodes the three mode bits into one of six named modes:
- CM_REG: registered output.
- CM_RIO: combinational I/O in a registered device.
- CM_COUT: dedicated combinational output.
- CM_NIO: combinational I/O in a non-registered device.
- CM_DIN: dedicated input.
- CM_BAD: any combination that is not listed.

The mode is a pure decode of static configuration, so no cell moves from one mode to another by itself. Its only sequential element is the output flip-flop. That flip-flop clears at power-up, captures the polarity-adjusted sum on each rising clock edge, and can be loaded from a test preload port instead.

Some feedback goes to a neighbouring pin:
- Cells in the lower half take the pin one position below.
- Cells in the upper half take the pin one position above.
- Cell 0 takes the level of the global enable pin.
- Cell 7 takes the level of the clock pin.

Top module: `mcb_bank`

## Requirements
- R1: Mode is decoded from {cfg_noreg, cfg_io, cfg_sel[i]}. The listed modes are: 010 registered, 011 combinational I/O in a registered device, 100 dedicated output, 111 combinational I/O in a non-registered device, and 101 dedicated input. Any other combination (000, 001, 110) gives pad_oe[i]=0 and fb[i]=0.
- R2: The polarity stage produces the value p = sum_term[i] when cfg_pol[i]=1 and p = ~sum_term[i] when cfg_pol[i]=0. In every combinational output mode, pad_out[i] equals p.
- R3: In registered mode, the cell flip-flop captures p on the rising clock edge. Both pad_out[i] and fb[i] show the flip-flop value, and they do not change between edges.
- R4: In registered mode, pad_oe[i] is 1 exactly when oe_pin_n is 0.
- R5: In both combinational I/O modes (011 and 111), pad_oe[i] equals en_term[i] and fb[i] equals pad_in[i].
- R6: In dedicated output mode (100), pad_oe[i] is always 1. fb[i] is the neighbour pin, except that cells 3 and 4 feed back 0.
- R7: In dedicated input mode (101), pad_oe[i] is 0 and fb[i] is the neighbour pin. The neighbour pin is:
  - oe_pin_n for cell 0;
  - clk_pin_lvl for cell 7;
  - pad_in[i-1] for cells 1 to 3;
  - pad_in[i+1] for cells 4 to 6.
- R8: While rst_n is low, every cell flip-flop is held at 0.
- R9: When preload is 1 at a rising edge, every flip-flop loads preload_val[i] instead of p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock (rising edge) |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| cfg_noreg | input | 1 | Global bit: 1 marks a device without registers |
| cfg_io | input | 1 | Global bit: I/O architecture select |
| cfg_sel | input | 8 | Per-cell mode select bit |
| cfg_pol | input | 8 | Per-cell polarity, 1 = active high |
| sum_term | input | 8 | Per-cell sum-of-products result |
| en_term | input | 8 | Per-cell enable product term |
| oe_pin_n | input | 1 | Global enable pin level, active low in registered mode |
| clk_pin_lvl | input | 1 | Logic level of the clock pin, used as a data input |
| preload | input | 1 | Synchronous test load of all flip-flops |
| preload_val | input | 8 | Values loaded by preload |
| pad_in | input | 8 | Level seen on each cell pin |
| pad_out | output | 8 | Value driven towards each pin |
| pad_oe | output | 8 | Pin drive enable per cell |
| fb | output | 8 | Feedback bit per cell to the logic array |

## Verification
On every cycle, the bound checker decodes the mode from the configuration ports on its own. It then confirms the enable source of each mode, the quiet state of undefined combinations, and that the flip-flop follows the adjusted sum or the preload value one edge later. Some behaviour only the directed scenarios can show:
- the exact neighbour routing in dedicated output and input modes, including the two end pins and the silent middle cells;
- the state held during reset;
- a mixed registered device in which some cells are registered and some are combinational.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
    typedef enum logic [2:0] {
        CM_REG,
        CM_RIO,
        CM_COUT,
        CM_NIO,
        CM_DIN,
        CM_BAD
    } cell_mode_e;
endpackage

// File: rtl/mcb_mode_dec.sv
module mcb_mode_dec
    import mcb_pkg::*;
(
    input  logic       noreg,
    input  logic       io_arch,
    input  logic       sel,
    output cell_mode_e mode
);
    always_comb begin
        unique case ({noreg, io_arch, sel})
            3'b010:  mode = CM_REG;
            3'b011:  mode = CM_RIO;
            3'b100:  mode = CM_COUT;
            3'b101:  mode = CM_DIN;
            3'b111:  mode = CM_NIO;
            3'b000:  mode = CM_BAD;
            3'b001:  mode = CM_BAD;
            3'b110:  mode = CM_BAD;
        endcase
    end
endmodule

// File: rtl/mcb_cell.sv
module mcb_cell
    import mcb_pkg::*;
#(
    parameter int IDX   = 0,
    parameter int NCELL = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  cell_mode_e mode,
    input  logic       pol,
    input  logic       sum,
    input  logic       en,
    input  logic       oe_n,
    input  logic       pad_self,
    input  logic       pad_adj,
    input  logic       preload,
    input  logic       pre_bit,
    output logic       pad_out,
    output logic       pad_oe,
    output logic       fb
);
    localparam bit SILENT_MID = (IDX == NCELL/2 - 1) || (IDX == NCELL/2);

    logic dval;
    logic q;

    assign dval = sum ^ ~pol;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (preload) begin
            q <= pre_bit;
        end else begin
            q <= dval;
        end
    end

    always_comb begin
        unique case (mode)
            CM_REG: begin
                pad_out = q;
                pad_oe  = ~oe_n;
                fb      = q;
            end
            CM_RIO: begin
                pad_out = dval;
                pad_oe  = en;
                fb      = pad_self;
            end
            CM_COUT: begin
                pad_out = dval;
                pad_oe  = 1'b1;
                fb      = SILENT_MID ? 1'b0 : pad_adj;
            end
            CM_NIO: begin
                pad_out = dval;
                pad_oe  = en;
                fb      = pad_self;
            end
            CM_DIN: begin
                pad_out = dval;
                pad_oe  = 1'b0;
                fb      = pad_adj;
            end
            CM_BAD: begin
                pad_out = dval;
                pad_oe  = 1'b0;
                fb      = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mcb_bank.sv
module mcb_bank
    import mcb_pkg::*;
#(
    parameter int NCELL = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_noreg,
    input  logic             cfg_io,
    input  logic [NCELL-1:0] cfg_sel,
    input  logic [NCELL-1:0] cfg_pol,
    input  logic [NCELL-1:0] sum_term,
    input  logic [NCELL-1:0] en_term,
    input  logic             oe_pin_n,
    input  logic             clk_pin_lvl,
    input  logic             preload,
    input  logic [NCELL-1:0] preload_val,
    input  logic [NCELL-1:0] pad_in,
    output logic [NCELL-1:0] pad_out,
    output logic [NCELL-1:0] pad_oe,
    output logic [NCELL-1:0] fb
);
    localparam int HALF = NCELL / 2;

    cell_mode_e       mode [NCELL];
    logic [NCELL-1:0] adj;

    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        if (i == 0) begin : g_adj_lo_end
            assign adj[i] = oe_pin_n;
        end else if (i == NCELL - 1) begin : g_adj_hi_end
            assign adj[i] = clk_pin_lvl;
        end else if (i < HALF) begin : g_adj_down
            assign adj[i] = pad_in[i-1];
        end else begin : g_adj_up
            assign adj[i] = pad_in[i+1];
        end

        mcb_mode_dec i_dec (
            .noreg   (cfg_noreg),
            .io_arch (cfg_io),
            .sel     (cfg_sel[i]),
            .mode    (mode[i])
        );

        mcb_cell #(.IDX(i), .NCELL(NCELL)) i_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode     (mode[i]),
            .pol      (cfg_pol[i]),
            .sum      (sum_term[i]),
            .en       (en_term[i]),
            .oe_n     (oe_pin_n),
            .pad_self (pad_in[i]),
            .pad_adj  (adj[i]),
            .preload  (preload),
            .pre_bit  (preload_val[i]),
            .pad_out  (pad_out[i]),
            .pad_oe   (pad_oe[i]),
            .fb       (fb[i])
        );
    end
endmodule

// File: rtl/mcb_bank_chk.sv
module mcb_bank_chk #(
    parameter int NCELL = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_noreg,
    input logic             cfg_io,
    input logic [NCELL-1:0] cfg_sel,
    input logic [NCELL-1:0] cfg_pol,
    input logic [NCELL-1:0] sum_term,
    input logic [NCELL-1:0] en_term,
    input logic             oe_pin_n,
    input logic             preload,
    input logic [NCELL-1:0] preload_val,
    input logic [NCELL-1:0] pad_out,
    input logic [NCELL-1:0] pad_oe,
    input logic [NCELL-1:0] fb
);
    for (genvar i = 0; i < NCELL; i++) begin : g_chk
        logic is_reg, is_io, is_cout, is_din, is_bad;
        assign is_reg  = !cfg_noreg &&  cfg_io && !cfg_sel[i];
        assign is_io   =  cfg_io && cfg_sel[i];
        assign is_cout =  cfg_noreg && !cfg_io && !cfg_sel[i];
        assign is_din  =  cfg_noreg && !cfg_io &&  cfg_sel[i];
        assign is_bad  = (!cfg_noreg && !cfg_io) || (cfg_noreg && cfg_io && !cfg_sel[i]);

        p_bad_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
            is_bad |-> (!pad_oe[i] && !fb[i]));

        p_comb_pol_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (is_io || is_cout) |-> (pad_out[i] == (sum_term[i] ~^ cfg_pol[i])));

        p_reg_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (is_reg && $past(rst_n) && !$past(preload))
                |-> (pad_out[i] == $past(sum_term[i] ~^ cfg_pol[i])));

        p_reg_fb_r3: assert property (@(posedge clk) disable iff (!rst_n)
            is_reg |-> (fb[i] == pad_out[i]));

        p_reg_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
            is_reg |-> (pad_oe[i] == !oe_pin_n));

        p_io_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
            is_io |-> (pad_oe[i] == en_term[i]));

        p_cout_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
            is_cout |-> pad_oe[i]);

        p_din_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
            is_din |-> !pad_oe[i]);

        p_preload_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (is_reg && $past(rst_n) && $past(preload))
                |-> (pad_out[i] == $past(preload_val[i])));
    end
endmodule

bind mcb_bank mcb_bank_chk #(.NCELL(NCELL)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_noreg   (cfg_noreg),
    .cfg_io      (cfg_io),
    .cfg_sel     (cfg_sel),
    .cfg_pol     (cfg_pol),
    .sum_term    (sum_term),
    .en_term     (en_term),
    .oe_pin_n    (oe_pin_n),
    .preload     (preload),
    .preload_val (preload_val),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .fb          (fb)
);

// File: tb/test_mcb_bank.sv
`timescale 1ns/1ps
module test_mcb_bank;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_noreg, cfg_io;
    logic [7:0] cfg_sel, cfg_pol, sum_term, en_term;
    logic       oe_pin_n, clk_pin_lvl, preload;
    logic [7:0] preload_val, pad_in;
    logic [7:0] pad_out, pad_oe, fb;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mcb_bank #(.NCELL(8)) i_mcb_bank (
        .clk(clk), .rst_n(rst_n), .cfg_noreg(cfg_noreg), .cfg_io(cfg_io),
        .cfg_sel(cfg_sel), .cfg_pol(cfg_pol), .sum_term(sum_term),
        .en_term(en_term), .oe_pin_n(oe_pin_n), .clk_pin_lvl(clk_pin_lvl),
        .preload(preload), .preload_val(preload_val), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .fb(fb)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] polar(input logic [7:0] s, input logic [7:0] p);
        return s ~^ p;
    endfunction

    function automatic logic [7:0] nbr(input logic [7:0] pads, input logic oe, input logic ck);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            if (i == 0)      r[i] = oe;
            else if (i == 7) r[i] = ck;
            else if (i < 4)  r[i] = pads[i-1];
            else             r[i] = pads[i+1];
        end
        return r;
    endfunction

    task automatic t_reset();
        rst_n = 1'b0; cfg_noreg = 1'b0; cfg_io = 1'b1; cfg_sel = 8'h00;
        cfg_pol = 8'hFF; sum_term = 8'hFF; en_term = 8'h00; oe_pin_n = 1'b0;
        clk_pin_lvl = 1'b0; preload = 1'b0; preload_val = 8'h00; pad_in = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check("R8 reset holds flip-flops", pad_out, 8'h00);
        check("R8 reset feedback", fb, 8'h00);
        rst_n = 1'b1;
    endtask

    task automatic t_registered();
        @(negedge clk);
        sum_term = 8'h00; cfg_pol = 8'hFF;
        @(posedge clk); #1;
        check("R3 capture zero", pad_out, 8'h00);
        @(negedge clk);
        sum_term = 8'h5A; cfg_pol = 8'hF0; #1;
        check("R3 holds between edges", pad_out, 8'h00);
        @(posedge clk); #1;
        check("R3 R2 registered polarity", pad_out, polar(8'h5A, 8'hF0));
        check("R3 feedback from register", fb, polar(8'h5A, 8'hF0));
        check("R4 enable with pin low", pad_oe, 8'hFF);
        @(negedge clk);
        oe_pin_n = 1'b1; #1;
        check("R4 disable with pin high", pad_oe, 8'h00);
        oe_pin_n = 1'b0;
    endtask

    task automatic t_preload();
        @(negedge clk);
        sum_term = 8'h00; cfg_pol = 8'hFF; preload = 1'b1; preload_val = 8'hC3;
        @(posedge clk); #1;
        check("R9 preload wins over capture", pad_out, 8'hC3);
        @(negedge clk);
        preload = 1'b0;
        @(posedge clk); #1;
        check("R9 normal capture resumes", pad_out, 8'h00);
    endtask

    task automatic t_mixed_reg_dev();
        @(negedge clk);
        cfg_noreg = 1'b0; cfg_io = 1'b1; cfg_sel = 8'h0F;
        sum_term = 8'h96; cfg_pol = 8'h3C; en_term = 8'h05; pad_in = 8'hA7; #1;
        check("R5 I/O enable from term", pad_oe, {4'hF, 4'h5});
        check("R5 I/O feedback from own pin", fb[3:0], pad_in[3:0]);
        check("R2 combinational polarity", pad_out[3:0], polar(8'h96, 8'h3C) & 8'h0F);
        @(posedge clk); #1;
        check("R3 registered half of mixed device", pad_out[7:4], polar(8'h96, 8'h3C) >> 4);
    endtask

    task automatic t_cout();
        @(negedge clk);
        cfg_noreg = 1'b1; cfg_io = 1'b0; cfg_sel = 8'h00;
        sum_term = 8'h3B; cfg_pol = 8'h55; pad_in = 8'hFF; oe_pin_n = 1'b1;
        clk_pin_lvl = 1'b1; #1;
        check("R6 output always enabled", pad_oe, 8'hFF);
        check("R2 dedicated output polarity", pad_out, polar(8'h3B, 8'h55));
        check("R6 neighbour feedback, middle cells silent", fb,
              nbr(8'hFF, 1'b1, 1'b1) & 8'hE7);
        pad_in = 8'h42; oe_pin_n = 1'b0; clk_pin_lvl = 1'b1; #1;
        check("R6 neighbour feedback pattern", fb, nbr(8'h42, 1'b0, 1'b1) & 8'hE7);
    endtask

    task automatic t_din();
        @(negedge clk);
        cfg_noreg = 1'b1; cfg_io = 1'b0; cfg_sel = 8'hFF;
        pad_in = 8'h6D; oe_pin_n = 1'b1; clk_pin_lvl = 1'b0; #1;
        check("R7 input mode disables outputs", pad_oe, 8'h00);
        check("R7 neighbour feedback", fb, nbr(8'h6D, 1'b1, 1'b0));
        pad_in = 8'h92; oe_pin_n = 1'b0; clk_pin_lvl = 1'b1; #1;
        check("R7 end cells take enable and clock pins", fb, nbr(8'h92, 1'b0, 1'b1));
    endtask

    task automatic t_nio();
        @(negedge clk);
        cfg_noreg = 1'b1; cfg_io = 1'b1; cfg_sel = 8'hFF;
        en_term = 8'hA9; pad_in = 8'h1E; sum_term = 8'hF1; cfg_pol = 8'h0F; #1;
        check("R5 non-registered I/O enable", pad_oe, 8'hA9);
        check("R5 non-registered I/O feedback", fb, 8'h1E);
        check("R2 non-registered I/O polarity", pad_out, polar(8'hF1, 8'h0F));
    endtask

    task automatic t_bad();
        @(negedge clk);
        cfg_noreg = 1'b1; cfg_io = 1'b1; cfg_sel = 8'h00;
        en_term = 8'hFF; pad_in = 8'hFF; oe_pin_n = 1'b1; clk_pin_lvl = 1'b1; #1;
        check("R1 combination 110 disabled", pad_oe, 8'h00);
        check("R1 combination 110 feedback zero", fb, 8'h00);
        cfg_noreg = 1'b0; cfg_io = 1'b0; cfg_sel = 8'hF0; oe_pin_n = 1'b0; #1;
        check("R1 combinations 000 and 001 disabled", pad_oe, 8'h00);
        check("R1 combinations 000 and 001 feedback zero", fb, 8'h00);
    endtask

    initial begin
        t_reset();
        t_registered();
        t_preload();
        t_mixed_reg_dev();
        t_cout();
        t_din();
        t_nio();
        t_bad();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule